// File: doc/BRIEF.md
# Cable-Compensated Second Pulse Generator

This block makes a once-per-second pulse that is launched early so that it reaches the far end of a cable exactly on the second. It runs from a fabric clock locked to a frequency reference, with four nanoseconds per cycle. It keeps a time-of-second value that advances by 4 ns every cycle. Each cycle it emits a 4-bit parallel word for a 4:1 output serializer. Choosing which bit of that word carries the edge gives 1 ns edge placement, even though the logic runs at a quarter of that rate.

Three settings control the pulse. A cable delay moves the pulse earlier. A signed fractional-second correction, as reported by a timing receiver, moves it later or earlier. A width in cycles sets how long the pulse stays high. All three are captured only at the end of a second, so a change made at any time affects only the seconds that follow. The counter keeps running on its own whatever happens to the settings, so pulses continue through any gap in external timing input.

Top module: `pps_edge_gen`

## Requirements
- R1: During reset and one cycle after it, `ser_word` is 0. The first second after reset (cycle indices 0 to NS_PER_SEC/4-1) produces no pulse.
- R2: Each second lasts exactly NS_PER_SEC/4 cycles. The time within the second, 4 × the cycle index, starts at 0 after reset, grows by 4 each cycle and wraps to 0 after NS_PER_SEC-4.
- R3: The rising edge of a second falls at in-second time T = (NS_PER_SEC − cable_delay_ns + sec_corr_ns) mod NS_PER_SEC, with the result in 0..NS_PER_SEC-1. Valid ranges are 0 ≤ cable_delay_ns < NS_PER_SEC and |sec_corr_ns| < NS_PER_SEC. The corrected sum may be negative or at least NS_PER_SEC before it wraps.
- R4: `ser_word` bit 0 is sent first, and each bit covers 1 ns. The word that holds the rising edge has bits T[1:0]..3 high and the lower bits low. T[CW-1:2] selects the cycle. The word appears one cycle after the cycle that T selects.
- R5: The pulse stays high for exactly 4 × pulse_cycles ns. Its falling word has high only the bits below T[1:0], so it falls at the same sub-cycle position as it rose. With pulse_cycles = 0, the second has no pulse.
- R6: The three settings are sampled only in the last cycle of a second and apply to the next second. A change at any other cycle does not move, resize or suppress the pulse of the current second.
- R7: Each second after the first has exactly one rising edge when its pulse_cycles > 0, and none when it is 0. With constant settings the pulse repeats once per second indefinitely. A pulse may run past the end of its second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, 4 ns per cycle, locked to the reference |
| rst | input | 1 | Synchronous active-high reset |
| cable_delay_ns | input | CW = $clog2(NS_PER_SEC+1) | Cable delay the pulse is launched ahead of, in ns |
| sec_corr_ns | input | CW+1 (signed) | Fractional-second correction added to the edge time, in ns |
| pulse_cycles | input | LEN_W | Pulse width in 4 ns cycles; 0 suppresses the pulse |
| ser_word | output | 4 | Registered serializer word, bit 0 transmitted first |

## Verification
The bench builds the block with NS_PER_SEC = 400 and LEN_W = 4, which makes a second only 100 cycles long. Sixty seconds can then be run, and every serializer bit of every cycle can be compared with an expected value computed from the absolute nanosecond time. In that small setting the settings step through all four sub-cycle edge positions. They also reach an edge at time 0, an edge one nanosecond after the boundary, and a corrected sum that wraps from below zero and from above one second. A pulse that crosses into the next second, a zero width, and distracting mid-second setting changes are covered too. A rising-edge count per second confirms that no pulse is doubled or dropped.

// File: rtl/pps_edge_pkg.sv
package pps_edge_pkg;

  localparam int unsigned SER_BITS = 4;

  typedef logic [SER_BITS-1:0] ser_word_t;

  // Word holding a rising edge: bits at and after the edge position are high.
  function automatic ser_word_t lead_mask(input logic [1:0] pos);
    ser_word_t ones;
    ones = '1;
    return ones << pos;
  endfunction

  // Word holding a falling edge: only bits before the edge position are high.
  function automatic ser_word_t trail_mask(input logic [1:0] pos);
    ser_word_t ones;
    ones = '1;
    return ~(ones << pos);
  endfunction

endpackage

// File: rtl/pps_cycle_counter.sv
module pps_cycle_counter #(
  parameter int CYC_PER_SEC = 250_000_000,
  parameter int CYC_W       = 28
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CYC_W-1:0] cyc_idx,
  output logic             sec_last
);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(CYC_PER_SEC - 1);

  assign sec_last = (cyc_idx == LAST_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_idx <= '0;
    end else if (sec_last) begin
      cyc_idx <= '0;
    end else begin
      cyc_idx <= cyc_idx + CYC_W'(1);
    end
  end
endmodule

// File: rtl/pps_target_latch.sv
module pps_target_latch #(
  parameter int NS_PER_SEC = 1_000_000_000,
  parameter int CW         = 30,
  parameter int LEN_W      = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [CW-1:0]       delay_ns,
  input  logic signed [CW:0]  corr_ns,
  input  logic [LEN_W-1:0]    len_in,
  output logic [CW-1:0]       tgt_ns,
  output logic [LEN_W-1:0]    len_q
);
  localparam int SW = CW + 3;
  localparam logic signed [SW-1:0] NS_S = SW'(NS_PER_SEC);

  logic signed [SW-1:0] raw_sum;
  logic signed [SW-1:0] wrapped;

  always_comb begin
    raw_sum = NS_S - $signed({3'b000, delay_ns}) + SW'(corr_ns);
    if (raw_sum < 0) begin
      wrapped = raw_sum + NS_S;
    end else if (raw_sum >= NS_S) begin
      wrapped = raw_sum - NS_S;
    end else begin
      wrapped = raw_sum;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_ns <= '0;
      len_q  <= '0;
    end else if (load) begin
      tgt_ns <= CW'(wrapped);
      len_q  <= len_in;
    end
  end
endmodule

// File: rtl/pps_word_shaper.sv
module pps_word_shaper
  import pps_edge_pkg::*;
#(
  parameter int CW    = 30,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-3:0]    cyc_idx,
  input  logic [CW-1:0]    tgt_ns,
  input  logic [LEN_W-1:0] len,
  output ser_word_t        word_q
);
  logic             busy;
  logic [LEN_W-1:0] remain;
  logic [1:0]       pos_q;
  logic             hit;
  ser_word_t        word_d;

  assign hit = (cyc_idx == tgt_ns[CW-1:2]) && (len != '0);

  always_comb begin
    word_d = '0;
    if (hit) begin
      word_d = lead_mask(tgt_ns[1:0]);
    end else if (busy) begin
      word_d = (remain == '0) ? trail_mask(pos_q) : '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
      pos_q  <= '0;
      word_q <= '0;
    end else begin
      word_q <= word_d;
      if (hit) begin
        busy   <= 1'b1;
        remain <= len - LEN_W'(1);
        pos_q  <= tgt_ns[1:0];
      end else if (busy) begin
        if (remain == '0) begin
          busy <= 1'b0;
        end else begin
          remain <= remain - LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pps_edge_gen.sv
module pps_edge_gen
  import pps_edge_pkg::*;
#(
  parameter int NS_PER_SEC = 1_000_000_000,
  parameter int LEN_W      = 16,
  localparam int CW        = $clog2(NS_PER_SEC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CW-1:0]      cable_delay_ns,
  input  logic signed [CW:0] sec_corr_ns,
  input  logic [LEN_W-1:0]   pulse_cycles,
  output logic [3:0]         ser_word
);
  localparam int CYC_PER_SEC = NS_PER_SEC / 4;
  localparam int CYC_W       = CW - 2;

  logic [CYC_W-1:0] cyc_idx;
  logic             sec_last;
  logic [CW-1:0]    tgt_ns;
  logic [LEN_W-1:0] len_q;
  ser_word_t        word_q;

  pps_cycle_counter #(.CYC_PER_SEC(CYC_PER_SEC), .CYC_W(CYC_W)) u_cnt (
    .clk(clk), .rst(rst), .cyc_idx(cyc_idx), .sec_last(sec_last)
  );

  pps_target_latch #(.NS_PER_SEC(NS_PER_SEC), .CW(CW), .LEN_W(LEN_W)) u_tgt (
    .clk(clk), .rst(rst), .load(sec_last),
    .delay_ns(cable_delay_ns), .corr_ns(sec_corr_ns), .len_in(pulse_cycles),
    .tgt_ns(tgt_ns), .len_q(len_q)
  );

  pps_word_shaper #(.CW(CW), .LEN_W(LEN_W)) u_shape (
    .clk(clk), .rst(rst), .cyc_idx(cyc_idx), .tgt_ns(tgt_ns),
    .len(len_q), .word_q(word_q)
  );

  assign ser_word = word_q;
endmodule

// File: rtl/pps_edge_gen_chk.sv
module pps_edge_gen_chk #(
  parameter int CYC_PER_SEC = 250_000_000,
  parameter int CYC_W       = 28,
  parameter int CW          = 30
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       ser_word,
  input logic [CYC_W-1:0] cyc_idx,
  input logic [CW-1:0]    tgt_ns
);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(CYC_PER_SEC - 1);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_d) begin
      reset_word_chk: assert (ser_word == 4'b0000);
    end
  end

  // R2
  cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_idx != LAST_CYC) |=> (cyc_idx == $past(cyc_idx) + CYC_W'(1)));

  // R2
  cyc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_idx == LAST_CYC) |=> (cyc_idx == '0));

  // R4
  word_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_word inside {4'b0000, 4'b1111, 4'b1110, 4'b1100, 4'b1000,
                      4'b0001, 4'b0011, 4'b0111}));

  // R5
  partial_rise_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_word[3] && !ser_word[0]) |=> ser_word[0]);

  // R6
  target_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_idx != LAST_CYC) |=> $stable(tgt_ns));
endmodule

bind pps_edge_gen pps_edge_gen_chk #(
  .CYC_PER_SEC(CYC_PER_SEC), .CYC_W(CYC_W), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .ser_word(ser_word), .cyc_idx(cyc_idx), .tgt_ns(tgt_ns)
);

// File: tb/pps_edge_gen_test.sv
`timescale 1ns/1ps
module pps_edge_gen_test;
  localparam int NS    = 400;
  localparam int CYC   = NS / 4;
  localparam int LEN_W = 4;
  localparam int CW    = $clog2(NS + 1);
  localparam int NSEC  = 60;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [CW-1:0]      cable_delay_ns = '0;
  logic signed [CW:0] sec_corr_ns = '0;
  logic [LEN_W-1:0]   pulse_cycles = '0;
  logic [3:0]         ser_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int cfg_d [0:NSEC];
  int cfg_c [0:NSEC];
  int cfg_l [0:NSEC];
  int cfg_t [0:NSEC];
  int rises [0:NSEC];

  always #4 clk = ~clk;

  pps_edge_gen #(.NS_PER_SEC(NS), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .cable_delay_ns(cable_delay_ns),
    .sec_corr_ns(sec_corr_ns), .pulse_cycles(pulse_cycles), .ser_word(ser_word)
  );

  // Edge time from R3, computed arithmetically.
  function automatic int edge_time(input int d, input int c);
    return ((NS - d + c) % NS + NS) % NS;
  endfunction

  // Expected line level at absolute ns time t (R3, R5, R6).
  function automatic bit exp_level(input int t);
    int s;
    bit r;
    s = t / NS;
    r = 0;
    for (int k = s - 1; k <= s; k++) begin
      if (k >= 1 && k <= NSEC && cfg_l[k] > 0) begin
        int rise;
        rise = k * NS + cfg_t[k];
        if (t >= rise && t < rise + 4 * cfg_l[k]) r = 1;
      end
    end
    return r;
  endfunction

  initial begin
    bit prev_bit;
    prev_bit = 0;
    for (int s = 0; s <= NSEC; s++) begin
      rises[s] = 0;
      if (s == 0)       begin cfg_d[s] = 0;   cfg_c[s] = 0;   cfg_l[s] = 0; end
      else if (s == 2)  begin cfg_d[s] = 0;   cfg_c[s] = 0;   cfg_l[s] = 0; end
      else if (s == 3)  begin cfg_d[s] = 0;   cfg_c[s] = 0;   cfg_l[s] = 2; end
      else if (s == 4)  begin cfg_d[s] = 399; cfg_c[s] = 0;   cfg_l[s] = 3; end
      else if (s == 5)  begin cfg_d[s] = 0;   cfg_c[s] = -1;  cfg_l[s] = 3; end
      else if (s == 7)  begin cfg_d[s] = 10;  cfg_c[s] = 50;  cfg_l[s] = 1; end
      else if (s == 8)  begin cfg_d[s] = 399; cfg_c[s] = -50; cfg_l[s] = 2; end
      else if (s >= 50) begin cfg_d[s] = 100; cfg_c[s] = 5;   cfg_l[s] = 4; end
      else begin
        cfg_d[s] = 40 + (s * 37) % 300;
        cfg_c[s] = (s * 53) % 71 - 40;
        cfg_l[s] = s % 7;
      end
      cfg_t[s] = edge_time(cfg_d[s], cfg_c[s]);
    end

    repeat (3) @(negedge clk);
    checks++;
    if (ser_word !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset word actual %b expected 0000", ser_word);
    end
    rst = 1'b0;

    for (int c = 1; c <= NSEC * CYC; c++) begin
      logic [3:0] exp_w;
      @(negedge clk);
      for (int b = 0; b < 4; b++) begin
        int t;
        t = 4 * (c - 1) + b;
        exp_w[b] = exp_level(t);
        if (ser_word[b] && !prev_bit) rises[t / NS]++;
        prev_bit = ser_word[b];
      end
      checks++;
      if (ser_word !== exp_w) begin
        errors++;
        $display("FAIL R1 R2 R3 R4 R5 R6 cycle %0d actual %b expected %b",
                 c, ser_word, exp_w);
      end
      // R6: distracting values mid-second, real values later in the same second.
      if (c % CYC == 20) begin
        cable_delay_ns = CW'((c * 7) % NS);
        sec_corr_ns    = (CW+1)'(25);
        pulse_cycles   = LEN_W'(9);
      end
      if (c % CYC == 50 && c / CYC + 1 <= NSEC) begin
        cable_delay_ns = CW'(cfg_d[c / CYC + 1]);
        sec_corr_ns    = (CW+1)'(cfg_c[c / CYC + 1]);
        pulse_cycles   = LEN_W'(cfg_l[c / CYC + 1]);
      end
    end

    // R7: one rising edge per second with nonzero width, none otherwise.
    for (int s = 0; s < NSEC; s++) begin
      int want;
      want = (cfg_l[s] > 0) ? 1 : 0;
      checks++;
      if (rises[s] != want) begin
        errors++;
        $display("FAIL R7 second %0d rising edges actual %0d expected %0d",
                 s, rises[s], want);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule